// File: doc/BRIEF.md
# Logic Unit with Zero-Count Check Prediction

This block is a 32-bit logic unit with concurrent error detection. It performs OR, AND, XOR, complement of X, and a one-place logical shift in either direction with a carry in and a carry out. Each operand arrives with a short check field, `ck1`: the number of zero bits in the operand, modulo 8. Alongside the logic operation, the block predicts the `ck1` of the result. The prediction uses only the operand check fields, the carries, and the zero count of one companion logic result (AND for OR and XOR, OR for AND). It then forms the second check part, `ck2`, which is the number of zero bits inside the predicted `ck1`.

The block also encodes the result it actually produced, using the same zero-count rule. It compares the actual check symbol `{ck1, ck2}` with the predicted one. Any difference sets a sticky error flag and a halt request. These stay set until reset. A fault in the datapath makes the two symbols differ, and so does a fault in the predictor or a corrupted operand check field. All outputs are registered and appear one clock after the inputs that produced them.

Top module: `chk_logic_unit`

## Requirements
- R1: While reset is high and on the first cycle after it, the outputs hold these values: result 0, carry out 0, predicted and actual `ck1` 0, predicted and actual `ck2` 2'b11, and error and halt both 0.
- R2: The result appears one clock after the inputs. Opcode 3'b000 gives X|Y, 3'b001 gives X&Y, 3'b010 gives X^Y and 3'b011 gives ~X. For all four, carry out is 0.
- R3: Opcode 3'b100 shifts left: the result is {X[30:0], cin} and carry out is X[31]. Opcode 3'b101 shifts right: the result is {cin, X[31:1]} and carry out is X[0].
- R4: Opcodes 3'b110 and 3'b111 pass X through unchanged with carry out 0. For these opcodes the predicted `ck1` equals the supplied X check field.
- R5: The actual `ck1` is the number of zero bits in the result, modulo 8. The actual `ck2` is the number of zero bits in the 3-bit `ck1`, as a 2-bit value.
- R6: The predicted `ck1` follows these rules, all modulo 8:
  - OR: Xc + Yc − z(X&Y)
  - AND: Xc + Yc − z(X|Y)
  - XOR: Xc + Yc − 2·z(X&Y) + 32
  - NOT: 32 − Xc
  - Both shifts: Xc + cout − cin
  
  Here z() is the zero count mod 8. When the supplied check fields are correct, the predicted `ck1` equals the actual `ck1`.
- R7: The predicted `ck2` is the number of zero bits in the predicted `ck1`.
- R8: When the registered predicted symbol differs from the actual symbol, error and halt are 1 in that same output cycle. When the supplied check fields are correct, error stays 0.
- R9: Once set, error and halt stay 1 until reset, whatever inputs follow.
- R10: The prediction is built from the supplied operand check fields and does not recount the operands. A wrong X check field shifts the predicted `ck1` by the same amount, modulo 8.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| op_i | input | 3 | Operation select |
| x_i | input | 32 | Operand X |
| y_i | input | 32 | Operand Y |
| x_ck1_i | input | 3 | Zero count of X mod 8 |
| y_ck1_i | input | 3 | Zero count of Y mod 8 |
| cin_i | input | 1 | Bit shifted in by the shift operations |
| res_o | output | 32 | Registered result |
| cout_o | output | 1 | Registered bit shifted out |
| pred_ck1_o | output | 3 | Predicted result `ck1` |
| pred_ck2_o | output | 2 | Predicted result `ck2` |
| act_ck1_o | output | 3 | `ck1` encoded from the result |
| act_ck2_o | output | 2 | `ck2` encoded from the result |
| err_o | output | 1 | Sticky check mismatch flag |
| halt_o | output | 1 | Halt request, equal to the error flag |

## Verification
The bench runs every opcode with both carry-in values over all ordered pairs of sixteen operand patterns. The patterns are all-zeros, all-ones, single set bits at both word ends, a single clear bit, four fixed mixed words and six random words.

The extreme patterns exercise the modulo-8 wrap of the zero count (32 zeros gives 0) and the XOR and complement correction terms. The end-bit patterns separate the two shift directions and show whether carry out is taken from the right end. The fixed mixed words pin the predicted OR and AND values to known results.

A deliberately wrong X check field is then applied. This separates a predictor that trusts its check inputs from one that recounts the operand. It also shows that the error flag rises, stays set, and clears only on reset.

// File: rtl/lu_pkg.sv
package lu_pkg;
  typedef enum logic [2:0] {
    OP_OR   = 3'd0,
    OP_AND  = 3'd1,
    OP_XOR  = 3'd2,
    OP_NOT  = 3'd3,
    OP_SHL  = 3'd4,
    OP_SHR  = 3'd5,
    OP_RSV6 = 3'd6,
    OP_RSV7 = 3'd7
  } lu_op_e;
endpackage

// File: rtl/lu_datapath.sv
module lu_datapath #(
  parameter int DATA_W = 32
) (
  input  lu_pkg::lu_op_e    op,
  input  logic [DATA_W-1:0] x,
  input  logic [DATA_W-1:0] y,
  input  logic              cin,
  output logic [DATA_W-1:0] res,
  output logic              cout,
  output logic [DATA_W-1:0] companion
);
  import lu_pkg::*;

  // Companion operation used by the predictor: OR when computing AND, else AND.
  assign companion = (op == OP_AND) ? (x | y) : (x & y);

  always_comb begin
    res  = x;
    cout = 1'b0;
    case (op)
      OP_OR:  res = x | y;
      OP_AND: res = x & y;
      OP_XOR: res = x ^ y;
      OP_NOT: res = ~x;
      OP_SHL: begin
        res  = {x[DATA_W-2:0], cin};
        cout = x[DATA_W-1];
      end
      OP_SHR: begin
        res  = {cin, x[DATA_W-1:1]};
        cout = x[0];
      end
      default: res = x;
    endcase
  end
endmodule

// File: rtl/zero_count_mod.sv
module zero_count_mod #(
  parameter int DATA_W = 32,
  parameter int CK1_W  = 3
) (
  input  logic [DATA_W-1:0] data,
  output logic [CK1_W-1:0]  ck1
);
  localparam int CNT_W = $clog2(DATA_W + 1);

  logic [CNT_W-1:0] cnt;

  always_comb begin
    cnt = '0;
    for (int i = 0; i < DATA_W; i++) cnt = cnt + CNT_W'(!data[i]);
  end

  // Truncation to CK1_W bits performs the modulo 2**CK1_W.
  assign ck1 = cnt[CK1_W-1:0];
endmodule

// File: rtl/ck2_gen.sv
module ck2_gen #(
  parameter int CK1_W = 3,
  parameter int CK2_W = 2
) (
  input  logic [CK1_W-1:0] ck1,
  output logic [CK2_W-1:0] ck2
);
  always_comb begin
    ck2 = '0;
    for (int i = 0; i < CK1_W; i++) ck2 = ck2 + CK2_W'(!ck1[i]);
  end
endmodule

// File: rtl/ck1_predict.sv
module ck1_predict #(
  parameter int DATA_W = 32,
  parameter int CK1_W  = 3
) (
  input  lu_pkg::lu_op_e   op,
  input  logic [CK1_W-1:0] x_ck1,
  input  logic [CK1_W-1:0] y_ck1,
  input  logic [CK1_W-1:0] comp_ck1,
  input  logic             cin,
  input  logic             cout,
  output logic [CK1_W-1:0] pred_ck1
);
  import lu_pkg::*;

  // Word width reduced modulo 2**CK1_W: the positive-offset term.
  localparam logic [CK1_W-1:0] WIDTH_MOD = CK1_W'(DATA_W);

  always_comb begin
    case (op)
      OP_OR, OP_AND: pred_ck1 = x_ck1 + y_ck1 - comp_ck1;
      OP_XOR:        pred_ck1 = x_ck1 + y_ck1 - (comp_ck1 << 1) + WIDTH_MOD;
      OP_NOT:        pred_ck1 = WIDTH_MOD - x_ck1;
      OP_SHL, OP_SHR: pred_ck1 = x_ck1 + CK1_W'(cout) - CK1_W'(cin);
      default:       pred_ck1 = x_ck1;
    endcase
  end
endmodule

// File: rtl/chk_logic_unit.sv
module chk_logic_unit #(
  parameter int DATA_W = 32,
  parameter int CK1_W  = 3,
  parameter int CK2_W  = $clog2(CK1_W + 1)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [2:0]        op_i,
  input  logic [DATA_W-1:0] x_i,
  input  logic [DATA_W-1:0] y_i,
  input  logic [CK1_W-1:0]  x_ck1_i,
  input  logic [CK1_W-1:0]  y_ck1_i,
  input  logic              cin_i,
  output logic [DATA_W-1:0] res_o,
  output logic              cout_o,
  output logic [CK1_W-1:0]  pred_ck1_o,
  output logic [CK2_W-1:0]  pred_ck2_o,
  output logic [CK1_W-1:0]  act_ck1_o,
  output logic [CK2_W-1:0]  act_ck2_o,
  output logic              err_o,
  output logic              halt_o
);
  import lu_pkg::*;

  // ck2 of an all-zero ck1 field: every bit is zero.
  localparam logic [CK2_W-1:0] CK2_OF_ZERO = CK2_W'(CK1_W);

  lu_op_e            op;
  logic [DATA_W-1:0] res_d, comp_d;
  logic              cout_d;
  logic [CK1_W-1:0]  comp_ck1, act_ck1_d, pred_ck1_d;
  logic [CK2_W-1:0]  act_ck2_d, pred_ck2_d;
  logic              mismatch;

  assign op = lu_op_e'(op_i);

  lu_datapath #(.DATA_W(DATA_W)) dp_i (
    .op(op), .x(x_i), .y(y_i), .cin(cin_i),
    .res(res_d), .cout(cout_d), .companion(comp_d)
  );

  zero_count_mod #(.DATA_W(DATA_W), .CK1_W(CK1_W)) comp_enc_i (
    .data(comp_d), .ck1(comp_ck1)
  );

  zero_count_mod #(.DATA_W(DATA_W), .CK1_W(CK1_W)) res_enc_i (
    .data(res_d), .ck1(act_ck1_d)
  );

  ck2_gen #(.CK1_W(CK1_W), .CK2_W(CK2_W)) act_ck2_i (
    .ck1(act_ck1_d), .ck2(act_ck2_d)
  );

  ck1_predict #(.DATA_W(DATA_W), .CK1_W(CK1_W)) pred_i (
    .op(op), .x_ck1(x_ck1_i), .y_ck1(y_ck1_i), .comp_ck1(comp_ck1),
    .cin(cin_i), .cout(cout_d), .pred_ck1(pred_ck1_d)
  );

  ck2_gen #(.CK1_W(CK1_W), .CK2_W(CK2_W)) pred_ck2_i (
    .ck1(pred_ck1_d), .ck2(pred_ck2_d)
  );

  assign mismatch = {pred_ck1_d, pred_ck2_d} != {act_ck1_d, act_ck2_d};

  always_ff @(posedge clk) begin
    if (rst) begin
      res_o      <= '0;
      cout_o     <= 1'b0;
      pred_ck1_o <= '0;
      pred_ck2_o <= CK2_OF_ZERO;
      act_ck1_o  <= '0;
      act_ck2_o  <= CK2_OF_ZERO;
      err_o      <= 1'b0;
    end else begin
      res_o      <= res_d;
      cout_o     <= cout_d;
      pred_ck1_o <= pred_ck1_d;
      pred_ck2_o <= pred_ck2_d;
      act_ck1_o  <= act_ck1_d;
      act_ck2_o  <= act_ck2_d;
      err_o      <= err_o | mismatch;
    end
  end

  assign halt_o = err_o;

  assert_shl_R3: assert property (@(posedge clk) disable iff (rst)
    (op_i == 3'd4) |=> (res_o == {$past(x_i[DATA_W-2:0]), $past(cin_i)})
                       && (cout_o == $past(x_i[DATA_W-1])));

  assert_shr_R3: assert property (@(posedge clk) disable iff (rst)
    (op_i == 3'd5) |=> (res_o == {$past(cin_i), $past(x_i[DATA_W-1:1])})
                       && (cout_o == $past(x_i[0])));

  assert_cout_idle_R3: assert property (@(posedge clk) disable iff (rst)
    (op_i != 3'd4 && op_i != 3'd5) |=> !cout_o);

  assert_act_ck2_R5: assert property (@(posedge clk) disable iff (rst)
    act_ck2_o == CK2_W'(CK1_W - $countones(act_ck1_o)));

  assert_pred_ck2_R7: assert property (@(posedge clk) disable iff (rst)
    pred_ck2_o == CK2_W'(CK1_W - $countones(pred_ck1_o)));

  assert_flag_on_mismatch_R8: assert property (@(posedge clk) disable iff (rst)
    ({pred_ck1_o, pred_ck2_o} != {act_ck1_o, act_ck2_o}) |-> err_o);

  assert_sticky_err_R9: assert property (@(posedge clk) disable iff (rst)
    err_o |=> err_o);
endmodule

// File: tb/chk_logic_unit_tb_top.sv
module chk_logic_unit_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int DW = 32;
  localparam int NPAT = 16;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic [2:0]    op_i = '0;
  logic [DW-1:0] x_i = '0, y_i = '0;
  logic [2:0]    x_ck1_i = '0, y_ck1_i = '0;
  logic          cin_i = 1'b0;
  logic [DW-1:0] res_o;
  logic          cout_o;
  logic [2:0]    pred_ck1_o, act_ck1_o;
  logic [1:0]    pred_ck2_o, act_ck2_o;
  logic          err_o, halt_o;

  int n_chk = 0;
  int n_bad = 0;
  bit done  = 1'b0;
  logic [DW-1:0] pats [NPAT];

  always #(CLK_PERIOD/2) clk = ~clk;

  chk_logic_unit dut_i (
    .clk(clk), .rst(rst), .op_i(op_i), .x_i(x_i), .y_i(y_i),
    .x_ck1_i(x_ck1_i), .y_ck1_i(y_ck1_i), .cin_i(cin_i),
    .res_o(res_o), .cout_o(cout_o), .pred_ck1_o(pred_ck1_o),
    .pred_ck2_o(pred_ck2_o), .act_ck1_o(act_ck1_o), .act_ck2_o(act_ck2_o),
    .err_o(err_o), .halt_o(halt_o)
  );

  task automatic check(input string tag, input logic [DW-1:0] got, input logic [DW-1:0] exp);
    n_chk++;
    if (got !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", tag, got, exp);
    end
  endtask

  function automatic logic [2:0] ck1_of(input logic [DW-1:0] v);
    int z = DW - $countones(v);
    return z[2:0];
  endfunction

  function automatic logic [1:0] ck2_of(input logic [2:0] c);
    int z = 3 - $countones(c);
    return z[1:0];
  endfunction

  task automatic apply(input logic [2:0] op, input logic [DW-1:0] x, input logic [DW-1:0] y,
                       input logic cin, input logic [2:0] xc, input logic [2:0] yc);
    @(negedge clk);
    op_i = op; x_i = x; y_i = y; cin_i = cin; x_ck1_i = xc; y_ck1_i = yc;
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic summary;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog R1 actual=running expected=finished");
      summary();
      $finish;
    end
  end

  initial begin
    logic [DW-1:0] er;
    logic          ec;
    logic [2:0]    bad_xc, exp_pred;
    string         tag;

    pats[0] = 32'h0000_0000; pats[1] = 32'hFFFF_FFFF;
    pats[2] = 32'hC503_F3A1; pats[3] = 32'h7ACA_5F53;
    pats[4] = 32'hC852_D329; pats[5] = 32'h4A46_5941;
    pats[6] = 32'h0000_0001; pats[7] = 32'h8000_0000;
    pats[8] = 32'h7FFF_FFFF; pats[9] = 32'hFFFF_FFFE;
    for (int k = 10; k < NPAT; k++) pats[k] = $urandom;

    // R1: reset state
    repeat (3) @(posedge clk);
    @(negedge clk);
    check("R1 res", res_o, 0);
    check("R1 cout", {31'b0, cout_o}, 0);
    check("R1 pred_ck1", {29'b0, pred_ck1_o}, 0);
    check("R1 pred_ck2", {30'b0, pred_ck2_o}, 3);
    check("R1 act_ck1", {29'b0, act_ck1_o}, 0);
    check("R1 act_ck2", {30'b0, act_ck2_o}, 3);
    check("R1 err", {31'b0, err_o}, 0);
    check("R1 halt", {31'b0, halt_o}, 0);
    rst = 1'b0;
    @(posedge clk); @(negedge clk);
    check("R1 err after release", {31'b0, err_o}, 0);

    // R6 with known words: OR -> ck1 5 ck2 1; AND -> ck1 0 ck2 3
    apply(3'd0, pats[2], pats[3], 1'b0, ck1_of(pats[2]), ck1_of(pats[3]));
    check("R6 known OR pred_ck1", {29'b0, pred_ck1_o}, 5);
    check("R7 known OR pred_ck2", {30'b0, pred_ck2_o}, 1);
    apply(3'd1, pats[4], pats[5], 1'b0, ck1_of(pats[4]), ck1_of(pats[5]));
    check("R6 known AND pred_ck1", {29'b0, pred_ck1_o}, 0);
    check("R7 known AND pred_ck2", {30'b0, pred_ck2_o}, 3);

    // Sweep: every opcode, both carries, all operand pairs
    for (int op = 0; op < 8; op++) begin
      for (int c = 0; c < 2; c++) begin
        for (int i = 0; i < NPAT; i++) begin
          for (int j = 0; j < NPAT; j++) begin
            apply(op[2:0], pats[i], pats[j], c[0], ck1_of(pats[i]), ck1_of(pats[j]));
            ec = 1'b0;
            case (op)
              0: er = pats[i] | pats[j];
              1: er = pats[i] & pats[j];
              2: er = pats[i] ^ pats[j];
              3: er = ~pats[i];
              4: begin er = {pats[i][DW-2:0], c[0]}; ec = pats[i][DW-1]; end
              5: begin er = {c[0], pats[i][DW-1:1]}; ec = pats[i][0]; end
              default: er = pats[i];
            endcase
            tag = (op < 4) ? "R2" : (op < 6) ? "R3" : "R4";
            check({tag, " res"}, res_o, er);
            check("R3 cout", {31'b0, cout_o}, {31'b0, ec});
            check("R5 act_ck1", {29'b0, act_ck1_o}, {29'b0, ck1_of(er)});
            check("R5 act_ck2", {30'b0, act_ck2_o}, {30'b0, ck2_of(ck1_of(er))});
            check("R6 pred_ck1", {29'b0, pred_ck1_o}, {29'b0, ck1_of(er)});
            check("R7 pred_ck2", {30'b0, pred_ck2_o}, {30'b0, ck2_of(ck1_of(er))});
            check("R8 no err", {31'b0, err_o}, 0);
          end
        end
      end
    end

    // R10/R8: corrupted X check field on an OR
    bad_xc = ck1_of(pats[2]) + 3'd3;
    exp_pred = bad_xc + ck1_of(pats[3]) - ck1_of(pats[2] & pats[3]);
    apply(3'd0, pats[2], pats[3], 1'b0, bad_xc, ck1_of(pats[3]));
    check("R10 pred_ck1 uses supplied field", {29'b0, pred_ck1_o}, {29'b0, exp_pred});
    check("R5 act_ck1 unaffected", {29'b0, act_ck1_o}, {29'b0, ck1_of(pats[2] | pats[3])});
    check("R8 err raised", {31'b0, err_o}, 1);
    check("R8 halt raised", {31'b0, halt_o}, 1);

    // R9: flag stays set on later clean vectors
    for (int k = 0; k < 4; k++) begin
      apply(3'd2, pats[k], pats[k+4], 1'b1, ck1_of(pats[k]), ck1_of(pats[k+4]));
      check("R9 err sticky", {31'b0, err_o}, 1);
      check("R9 halt sticky", {31'b0, halt_o}, 1);
    end

    // R1: reset clears the flag
    @(negedge clk); rst = 1'b1;
    @(posedge clk); @(negedge clk);
    check("R1 err cleared", {31'b0, err_o}, 0);
    check("R1 halt cleared", {31'b0, halt_o}, 0);
    check("R1 pred_ck2 reset", {30'b0, pred_ck2_o}, 3);
    rst = 1'b0;

    done = 1'b1;
    summary();
    $finish;
  end
endmodule